// File: doc/BRIEF.md
# Refresh Timer Control and Status Register

This block is the software-visible control word of an SDRAM controller's periodic refresh timer. It holds four fields. One is a compare-match flag, raised when the external refresh counter reaches its constant. The others are an interrupt enable, a 3-bit counter clock select and a 3-bit refresh request count. The block drives an interrupt request and passes the select fields and a counter-run signal to the timer logic.

Software writes are guarded by a key. A write only takes effect when its upper halfword carries that key, and any other write is dropped. The flag is cleared by a two-step handshake: software first reads the register while the flag is set, then writes zero to the flag bit. A power-on reset clears everything. A manual reset keeps the contents and only cancels a handshake that is in progress.

Top module: `rfsh_timer_csr`

## Requirements
- R1: While `rst_ni` is low, and right after it rises, `rdata_o`, `irq_o`, `cnt_en_o`, `clk_sel_o` and `rfsh_cnt_o` are all zero.
- R2: A write (`wr_en_i`) whose `wdata_i[31:16]` equals 16'hA55A loads bits 6:0 of the register from `wdata_i[6:0]` at that clock edge. A write carrying any other upper halfword changes nothing.
- R3: `rdata_o[31:8]` always reads zero. Keyed writes with ones in `wdata_i[31:8]` leave those bits at zero.
- R4: `cmp_match_i` high at a clock edge sets the flag, which reads as `rdata_o[7]` from that edge on.
- R5: A keyed write with `wdata_i[7]=0` clears the flag only when a read (`rd_en_i`) that returned the flag as 1 has happened since the last keyed write. Without such a read, the flag stays set.
- R6: Every keyed write cancels a pending read of the handshake, whatever the value of bit 7. A later zero write then leaves the flag set until a new read.
- R7: Writing 1 to bit 7 never sets the flag.
- R8: When `cmp_match_i` and a valid flag-clearing write fall on the same edge, the flag stays 1.
- R9: `irq_o` is high exactly when the flag (bit 7) and the interrupt enable (bit 6) are both set.
- R10: `clk_sel_o` mirrors bits 5:3 and `rfsh_cnt_o` mirrors bits 2:0. `cnt_en_o` is high exactly when `clk_sel_o` is nonzero; a value of 0 means the counter is stopped.
- R11: `mrst_ni` low at a clock edge leaves every register field unchanged but cancels a pending handshake read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| mrst_ni | input | 1 | Manual reset, synchronous, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| wdata_i | input | 32 | Write data with key in bits 31:16 |
| rdata_o | output | 32 | Current register value |
| cmp_match_i | input | 1 | Compare-match strobe from refresh counter |
| irq_o | output | 1 | Compare-match interrupt request |
| cnt_en_o | output | 1 | Refresh counter run enable |
| clk_sel_o | output | 3 | Counter clock select |
| rfsh_cnt_o | output | 3 | Refresh request count |

## Verification
The one piece of hidden state is the handshake latch. If it is wrong, the flag shows up at `rdata_o[7]` and `irq_o` one edge after a zero write: a latch that is stuck set clears the flag without any read, and a latch that is never set leaves it high after a proper read. A corrupted key compare or field register shows on the mirrored select outputs at the edge of the write. A mistake in set/clear priority shows one cycle after a collision.

// File: rtl/rfsh_timer_csr_pkg.sv
package rfsh_timer_csr_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned KEY_W   = 16;
  localparam int unsigned KEY_LSB = 16;
  localparam logic [KEY_W-1:0] WR_KEY = 16'hA55A;
  localparam int unsigned CKS_W = 3;
  localparam int unsigned RRC_W = 3;
  // field positions decoded by the timer logic and software
  localparam int unsigned RRC_LSB = 0;
  localparam int unsigned CKS_LSB = RRC_LSB + RRC_W;
  localparam int unsigned IE_BIT  = CKS_LSB + CKS_W;
  localparam int unsigned FLG_BIT = IE_BIT + 1;
  localparam int unsigned USED_W  = FLG_BIT + 1;

  typedef struct packed {
    logic             ie;
    logic [CKS_W-1:0] cks;
    logic [RRC_W-1:0] rrc;
  } cfg_t;
endpackage

// File: rtl/rfsh_key_gate.sv
module rfsh_key_gate
  import rfsh_timer_csr_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         wr_en_i,
  input  logic [W-1:0] wdata_i,
  output logic         wr_ok_o,
  output logic         flg_wr_o
);
  assign wr_ok_o  = wr_en_i && (wdata_i[KEY_LSB +: KEY_W] == WR_KEY);
  assign flg_wr_o = wdata_i[FLG_BIT];
endmodule

// File: rtl/rfsh_cfg_reg.sv
module rfsh_cfg_reg
  import rfsh_timer_csr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_ok_i,
  input  cfg_t cfg_d_i,
  output cfg_t cfg_q_o
);
  // manual reset deliberately not wired: contents survive it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfg_q_o <= '0;
    else if (wr_ok_i) cfg_q_o <= cfg_d_i;
  end
endmodule

// File: rtl/rfsh_flag_ctl.sv
module rfsh_flag_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mrst_ni,
  input  logic cmp_i,
  input  logic rd_en_i,
  input  logic wr_ok_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic seen_q;
  logic clr;

  assign clr = wr_ok_i && !wbit_i && seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (cmp_i) flag_o <= 1'b1;   // set wins over clear
    else if (clr)   flag_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               seen_q <= 1'b0;
    else if (!mrst_ni)         seen_q <= 1'b0;
    else if (wr_ok_i)          seen_q <= 1'b0;
    else if (rd_en_i && flag_o) seen_q <= 1'b1;
  end
endmodule

// File: rtl/rfsh_timer_csr.sv
module rfsh_timer_csr
  import rfsh_timer_csr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mrst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              cmp_match_i,
  output logic              irq_o,
  output logic              cnt_en_o,
  output logic [CKS_W-1:0]  clk_sel_o,
  output logic [RRC_W-1:0]  rfsh_cnt_o
);
  logic wr_ok, wbit, flag;
  cfg_t cfg_d, cfg_q;

  rfsh_key_gate #(.W(DATA_W)) u_gate (
    .wr_en_i (wr_en_i),
    .wdata_i (wdata_i),
    .wr_ok_o (wr_ok),
    .flg_wr_o(wbit)
  );

  assign cfg_d = cfg_t'(wdata_i[IE_BIT:0]);

  rfsh_cfg_reg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_ok_i(wr_ok),
    .cfg_d_i(cfg_d),
    .cfg_q_o(cfg_q)
  );

  rfsh_flag_ctl u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mrst_ni(mrst_ni),
    .cmp_i  (cmp_match_i),
    .rd_en_i(rd_en_i),
    .wr_ok_i(wr_ok),
    .wbit_i (wbit),
    .flag_o (flag)
  );

  always_comb begin
    rdata_o = '0;
    rdata_o[FLG_BIT] = flag;
    rdata_o[IE_BIT:0] = cfg_q;
  end

  assign irq_o      = flag & cfg_q.ie;
  assign clk_sel_o  = cfg_q.cks;
  assign rfsh_cnt_o = cfg_q.rrc;
  assign cnt_en_o   = |cfg_q.cks;
endmodule

// File: rtl/rfsh_timer_csr_chk.sv
module rfsh_timer_csr_chk
  import rfsh_timer_csr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              cmp_match_i,
  input logic              irq_o
);
  logic key_ok;
  assign key_ok = (wdata_i[KEY_LSB +: KEY_W] == WR_KEY);

  // R4
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_match_i |=> rdata_o[FLG_BIT]);

  // R8
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_match_i && wr_en_i && key_ok && !wdata_i[FLG_BIT]) |=> rdata_o[FLG_BIT]);

  // R2
  bad_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !key_ok && !cmp_match_i) |=> $stable(rdata_o));

  // R2
  good_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && key_ok) |=> rdata_o[IE_BIT:0] == $past(wdata_i[IE_BIT:0]));

  // R7
  no_sw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdata_o[FLG_BIT] && !cmp_match_i) |=> !rdata_o[FLG_BIT]);

  // R9
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> rdata_o[IE_BIT] && rdata_o[FLG_BIT]);
endmodule

bind rfsh_timer_csr rfsh_timer_csr_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .cmp_match_i(cmp_match_i),
  .irq_o      (irq_o)
);

// File: tb/rfsh_timer_csr_tb.sv
module rfsh_timer_csr_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mrst_ni = 1'b1;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        cmp_match_i = 1'b0;
  logic        irq_o, cnt_en_o;
  logic [2:0]  clk_sel_o, rfsh_cnt_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  rfsh_timer_csr u_dut (
    .clk_i, .rst_ni, .mrst_ni, .wr_en_i, .rd_en_i, .wdata_i, .rdata_o,
    .cmp_match_i, .irq_o, .cnt_en_o, .clk_sel_o, .rfsh_cnt_o
  );

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic        cmp;
    logic [31:0] wd;
    logic [7:0]  exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 32'hA55A_FFE5, 8'h65}, // R2 R3 R7 load fields, bit7 ignored
    '{1'b1, 1'b0, 1'b0, 32'h1234_0000, 8'h65}, // R2 bad key dropped
    '{1'b0, 1'b0, 1'b1, 32'h0000_0000, 8'hE5}, // R4 R9 set flag
    '{1'b1, 1'b0, 1'b0, 32'hA55A_0025, 8'hA5}, // R5 no read yet: flag stays
    '{1'b0, 1'b1, 1'b0, 32'h0000_0000, 8'hA5}, // R5 read arms
    '{1'b1, 1'b0, 1'b0, 32'hA55A_0040, 8'h40}, // R5 clear
    '{1'b0, 1'b0, 1'b1, 32'h0000_0000, 8'hC0}, // R4
    '{1'b0, 1'b1, 1'b0, 32'h0000_0000, 8'hC0},
    '{1'b1, 1'b0, 1'b0, 32'hA55A_00C0, 8'hC0}, // R6 write 1 cancels arm
    '{1'b1, 1'b0, 1'b0, 32'hA55A_0040, 8'hC0}, // R6 zero write w/o new read
    '{1'b0, 1'b1, 1'b0, 32'h0000_0000, 8'hC0},
    '{1'b1, 1'b0, 1'b1, 32'hA55A_0040, 8'hC0}, // R8 set wins
    '{1'b0, 1'b1, 1'b0, 32'h0000_0000, 8'hC0},
    '{1'b1, 1'b0, 1'b0, 32'hA55A_003F, 8'h3F}  // R5 R10 clear, full select
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [7:0] e);
    chk(req, rdata_o, {24'h0, e});
    chk("R3", {8'h0, rdata_o[31:8]}, 32'h0);
    chk("R9", {31'h0, irq_o}, {31'h0, e[7] & e[6]});
    chk("R10", {26'h0, clk_sel_o, rfsh_cnt_o}, {26'h0, e[5:3], e[2:0]});
    chk("R10", {31'h0, cnt_en_o}, {31'h0, e[5:3] != 3'd0});
  endtask

  // drive at negedge, let one posedge pass, sample at next negedge
  task automatic cyc(input logic w, input logic r, input logic c, input logic [31:0] d);
    wr_en_i = w; rd_en_i = r; cmp_match_i = c; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 0; rd_en_i = 0; cmp_match_i = 0; wdata_i = '0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    chk_all("R1", 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_all("R1", 8'h00);

    for (int i = 0; i < NV; i++) begin
      cyc(VECS[i].wr, VECS[i].rd, VECS[i].cmp, VECS[i].wd);
      chk_all($sformatf("vec%0d", i), VECS[i].exp);
    end

    // R11: manual reset keeps fields, cancels armed read
    cyc(1'b0, 1'b0, 1'b1, 32'h0);
    chk_all("R4", 8'hBF);
    cyc(1'b0, 1'b1, 1'b0, 32'h0);
    mrst_ni = 1'b0;
    @(negedge clk_i);
    mrst_ni = 1'b1;
    chk_all("R11", 8'hBF);
    cyc(1'b1, 1'b0, 1'b0, 32'hA55A_0012);
    chk_all("R11", 8'h92);
    cyc(1'b0, 1'b1, 1'b0, 32'h0);
    cyc(1'b1, 1'b0, 1'b0, 32'hA55A_0012);
    chk_all("R5", 8'h12);

    // R7: write 1 to bit7 with flag clear
    cyc(1'b1, 1'b0, 1'b0, 32'hA55A_0080);
    chk_all("R7", 8'h00);

    // R1: power-on reset mid-run
    cyc(1'b1, 1'b0, 1'b1, 32'hA55A_0077);
    chk_all("R4", 8'hF7);
    rst_ni = 1'b0;
    #3;
    chk_all("R1", 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_all("R1", 8'h00);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule